// File: doc/BRIEF.md
# Triangle Wave Overlay Generator

This block lays a small triangle waveform on top of a 12-bit DC base level. An internal up/down counter takes one step for each trigger pulse. It climbs from zero to a programmable peak, falls back to zero, and repeats. Each step lands three clock cycles after the trigger that caused it. In the same cycle the output sample is loaded with the base value plus the counter value held before the step. The sum saturates at full scale and never wraps.

The peak comes from a 4-bit amplitude code that is captured only while the channel enable is low. A 2-bit wave mode field selects triangle generation when its upper bit is set. Clearing that bit parks the counter at zero, ready to count up. The block sits between a trigger source and a converter's output register. Choosing the trigger source, generating noise and the analog conversion itself are handled elsewhere.

Top module: `tri_overlay_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `sample_o` and `tri_o` are cleared to 0 at that edge. The counter direction is set to up.
- R2: If `trig_i` is high at clock edge k, the resulting load and counter step happen at edge k+3. With no trigger three edges earlier, `sample_o` keeps its value, and so does `tri_o` while triangle mode is selected.
- R3: At a load edge, `sample_o` becomes min(`base_i` + C, 4095), where C is the counter value just before the step. C is taken as 0 when triangle mode is off. The sum never wraps.
- R4: In triangle mode, a step adds 1 while counting up and the counter is below the peak. At the peak, the step reverses direction and subtracts 1. While counting down, a step subtracts 1 until 0 is reached. At 0, the step reverses direction and adds 1. Each extreme is therefore held for exactly one step. For peak 1 the sequence is 0,1,0,1.
- R5: For amplitude code n from 0 to 10, the peak is 2^(n+1)-1 (1, 3, 7, ... 2047). Every code from 11 to 15 gives a peak of 4095.
- R6: `wave_i` values 2'b10 and 2'b11 both select triangle mode. With `wave_i[1]` low (2'b00 or 2'b01), the counter is forced to 0 in the up direction at every edge. A load then stores `base_i` alone. Returning to triangle mode restarts the ramp from 0 counting up.
- R7: The amplitude code is taken from `amp_i` only at edges where `en_i` is low. While `en_i` is high, changes on `amp_i` do not affect the peak.
- R8: Triggers on consecutive edges are each honoured. A burst of N back-to-back triggers produces N steps on N consecutive edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Trigger pulse, one step per edge where high |
| en_i | input | 1 | Channel enable; while high the amplitude code is frozen |
| wave_i | input | 2 | Wave mode; upper bit set selects triangle |
| amp_i | input | 4 | Amplitude code selecting the peak |
| base_i | input | 12 | DC base value |
| sample_o | output | 12 | Saturated sum of base and counter |
| tri_o | output | 12 | Current triangle counter value |

## Verification
The hardest condition to reach from the ports is the turn at a large peak. For codes 11 and above, the counter has to climb 4095 steps before the reversal and the saturating sum can be seen. Spaced single triggers would need four cycles per step. The stimulus therefore holds the trigger high for a burst of exactly the expected peak count. It then checks that one more step gives peak minus one. The frozen-amplitude case is reached by lowering the code while the enable is high. A ramp that passes the new, smaller peak then shows that the old peak is still in force.

// File: rtl/tri_overlay_pkg.sv
package tri_overlay_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } tri_dir_e;

  // Upper bit of the wave field selects triangle generation (10 and 11)
  function automatic logic wave_is_tri(input logic [1:0] wave);
    return wave[1];
  endfunction

endpackage

// File: rtl/tri_trig_delay.sv
module tri_trig_delay #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic fire_o
);

  logic [LAT-1:0] stage_q;

  generate
    if (LAT == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= trig_i;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= {stage_q[LAT-2:0], trig_i};
      end
    end
  endgenerate

  assign fire_o = stage_q[LAT-1];

endmodule

// File: rtl/tri_step_counter.sv
module tri_step_counter
  import tri_overlay_pkg::*;
#(
  parameter int DW = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [AW-1:0] amp_code_i,
  output logic [DW-1:0] cnt_o
);

  logic [DW-1:0] peak;
  logic [DW-1:0] cnt_q;
  tri_dir_e      dir_q;

  // Bit i of the peak is set when i <= code; codes past DW-1 give all ones
  always_comb begin
    for (int i = 0; i < DW; i++) begin
      peak[i] = (i <= int'(amp_code_i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (step_i) begin
      if (dir_q == DIR_UP) begin
        if (cnt_q < peak) begin
          cnt_q <= cnt_q + 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
          dir_q <= DIR_DOWN;
        end
      end else begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          dir_q <= DIR_UP;
        end
      end
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tri_sat_adder.sv
module tri_sat_adder #(
  parameter int DW = 12
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] sum_o
);

  logic [DW:0] wide;

  always_comb begin
    wide  = {1'b0, a_i} + {1'b0, b_i};
    sum_o = wide[DW] ? {DW{1'b1}} : wide[DW-1:0];
  end

endmodule

// File: rtl/tri_overlay_gen.sv
module tri_overlay_gen
  import tri_overlay_pkg::*;
#(
  parameter int DW  = 12,
  parameter int AW  = 4,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig_i,
  input  logic          en_i,
  input  logic [1:0]    wave_i,
  input  logic [AW-1:0] amp_i,
  input  logic [DW-1:0] base_i,
  output logic [DW-1:0] sample_o,
  output logic [DW-1:0] tri_o
);

  logic          fire;
  logic          tri_mode;
  logic [AW-1:0] amp_q;
  logic [DW-1:0] cnt;
  logic [DW-1:0] overlay;
  logic [DW-1:0] sum;
  logic [DW-1:0] sample_q;

  assign tri_mode = wave_is_tri(wave_i);

  // Amplitude code is only accepted while the channel is disabled
  always_ff @(posedge clk) begin
    if (rst)        amp_q <= '0;
    else if (!en_i) amp_q <= amp_i;
  end

  tri_trig_delay #(.LAT(LAT)) u_delay (
    .clk    (clk),
    .rst    (rst),
    .trig_i (trig_i),
    .fire_o (fire)
  );

  tri_step_counter #(.DW(DW), .AW(AW)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (!tri_mode),
    .step_i     (fire && tri_mode),
    .amp_code_i (amp_q),
    .cnt_o      (cnt)
  );

  assign overlay = tri_mode ? cnt : '0;

  tri_sat_adder #(.DW(DW)) u_add (
    .a_i   (base_i),
    .b_i   (overlay),
    .sum_o (sum)
  );

  always_ff @(posedge clk) begin
    if (rst)       sample_q <= '0;
    else if (fire) sample_q <= sum;
  end

  assign sample_o = sample_q;
  assign tri_o    = cnt;

endmodule

// File: rtl/tri_overlay_chk.sv
module tri_overlay_chk #(
  parameter int DW  = 12,
  parameter int LAT = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          trig_i,
  input logic [1:0]    wave_i,
  input logic [DW-1:0] base_i,
  input logic [DW-1:0] sample_o,
  input logic [DW-1:0] tri_o
);

  localparam logic [DW-1:0] ONE = 1;

  // Independent record of triggers seen LAT edges ago
  logic [LAT:0] seen_q;
  logic         due;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else     seen_q <= {seen_q[LAT-1:0], trig_i};
  end

  assign due = seen_q[LAT-1];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (sample_o == '0 && tri_o == '0)); // R1

  AST_QUIET_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    !due |=> $stable(sample_o)); // R2

  AST_QUIET_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!due && wave_i[1]) |=> $stable(tri_o)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    due |=> sample_o >= $past(base_i)); // R3

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (due && wave_i[1]) |=>
      (tri_o == $past(tri_o) + ONE || tri_o == $past(tri_o) - ONE)); // R4

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !wave_i[1] |=> tri_o == '0); // R6

endmodule

bind tri_overlay_gen tri_overlay_chk #(.DW(DW), .LAT(LAT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .trig_i   (trig_i),
  .wave_i   (wave_i),
  .base_i   (base_i),
  .sample_o (sample_o),
  .tri_o    (tri_o)
);

// File: tb/tb_tri_overlay_gen.sv
`timescale 1ns/1ps
module tb_tri_overlay_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_i = 1'b0;
  logic        en_i = 1'b0;
  logic [1:0]  wave_i = 2'b00;
  logic [3:0]  amp_i = 4'd0;
  logic [11:0] base_i = 12'd0;
  logic [11:0] sample_o;
  logic [11:0] tri_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  int m_cnt = 0;
  bit m_down = 1'b0;
  int m_peak = 1;
  int m_sample = 0;

  always #2 clk = ~clk;

  tri_overlay_gen dut (
    .clk(clk), .rst(rst), .trig_i(trig_i), .en_i(en_i), .wave_i(wave_i),
    .amp_i(amp_i), .base_i(base_i), .sample_o(sample_o), .tri_o(tri_o)
  );

  function automatic int peak_of(int code);
    return (code >= 11) ? 4095 : ((1 << (code + 1)) - 1);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic m_clear();
    m_cnt = 0;
    m_down = 1'b0;
  endtask

  task automatic m_step();
    int s;
    s = base_i + (wave_i[1] ? m_cnt : 0);
    m_sample = (s > 4095) ? 4095 : s;
    if (!wave_i[1]) begin
      m_clear();
    end else if (!m_down) begin
      if (m_cnt < m_peak) m_cnt++;
      else begin m_cnt--; m_down = 1'b1; end
    end else begin
      if (m_cnt > 0) m_cnt--;
      else begin m_cnt++; m_down = 1'b0; end
    end
  endtask

  // Called at a negedge; one trigger, checks hold then load
  task automatic one_trig(string req);
    int prev;
    prev = m_sample;
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    @(negedge clk);
    check("R2 hold", sample_o, prev);
    @(negedge clk);
    check("R2 hold", sample_o, prev);
    @(negedge clk);
    m_step();
    check(req, sample_o, m_sample);
    check(req, tri_o, m_cnt);
  endtask

  task automatic burst(int n);
    trig_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      m_step();
    end
    trig_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic restart(int code, int base);
    wave_i = 2'b00;
    en_i = 1'b0;
    amp_i = 4'(code);
    base_i = 12'(base);
    @(negedge clk);
    m_clear();
    m_peak = peak_of(code);
    wave_i = 2'b10;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 sample", sample_o, 0);
    check("R1 tri", tri_o, 0);
    rst = 1'b0;
    @(negedge clk);
    m_sample = 0;
  endtask

  task automatic t_ramp();
    restart(1, 100);
    for (int i = 0; i < 9; i++) one_trig("R3/R4 ramp peak3");
  endtask

  task automatic t_extremes();
    restart(0, 7);
    for (int i = 0; i < 5; i++) one_trig("R4 peak1");
    check("R4 sequence end", tri_o, 1);
  endtask

  task automatic t_saturate();
    restart(3, 4090);
    for (int i = 0; i < 12; i++) one_trig("R3 saturate");
    check("R3 top", m_sample, 4095);
  endtask

  task automatic t_codes();
    for (int code = 0; code < 16; code++) begin
      restart(code, 0);
      burst(peak_of(code));
      check("R5 peak", tri_o, peak_of(code));
      check("R8 burst sample", sample_o, peak_of(code) - 1);
      burst(1);
      check("R5 reverse", tri_o, peak_of(code) - 1);
    end
  endtask

  task automatic t_modes();
    restart(2, 300);
    burst(4);
    check("R6 counted", tri_o, 4);
    wave_i = 2'b00;
    @(negedge clk);
    m_clear();
    check("R6 clear", tri_o, 0);
    check("R6 sample kept", sample_o, m_sample);
    wave_i = 2'b01;
    one_trig("R6 mode01 base only");
    check("R6 mode01 no count", tri_o, 0);
    wave_i = 2'b11;
    one_trig("R6 mode11 triangle");
    check("R6 restart up", tri_o, 1);
  endtask

  task automatic t_freeze();
    restart(3, 0);
    en_i = 1'b1;
    @(negedge clk);
    amp_i = 4'd0;
    @(negedge clk);
    burst(15);
    check("R7 frozen peak", tri_o, 15);
    burst(1);
    check("R7 frozen reverse", tri_o, 14);
    en_i = 1'b0;
    @(negedge clk);
    restart(0, 0);
    burst(2);
    check("R7 new code taken", tri_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_ramp();
    t_extremes();
    t_saturate();
    t_codes();
    t_modes();
    t_freeze();
    done = 1'b1;
    summary();
  end

endmodule